// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block sits between a clocked host and an external asynchronous static RAM with 16-bit words. The host hands over one request at a time through a valid/ready handshake: an address, a write flag, write data and one enable bit per byte lane. The controller turns each request into a sequence of active-low memory strobes. It drives chip enable, output enable, write enable and one byte-lane enable per lane. It also drives the address, and it handles the bidirectional data bus through a separate output word, an input word and a drive-enable.

Every phase of the memory cycle lasts a whole number of clock cycles, and parameters set the counts. A write first drives address, data and lane strobes for one cycle. It then lowers write enable for a configurable pulse and holds everything for one more cycle after write enable rises, so the write always ends on the write-enable edge. A read holds chip and output enable low for a configurable wait, captures the bus at the end of it and then idles for a configurable turnaround before it accepts a new request. Completion comes back as a one-cycle read-valid pulse carrying the data, or as a one-cycle write-done pulse.

Top module: `sram_lane_ctrl`

## Requirements
- R1: Out of reset and whenever ready is high, chip, output and write enable are high, both lane strobes are high and the data drivers are off.
- R2: In a write, address, data and lane strobes are driven one full cycle before write enable falls and stay unchanged until the cycle after write enable rises. The data drivers stay on for that whole span.
- R3: Write enable stays low for exactly WR_PULSE cycles per write, and chip enable is low during the whole pulse.
- R4: Host enable bit 0 selects data bits 7:0 through lane strobe bit 0, and host enable bit 1 selects bits 15:8 through lane strobe bit 1. A lane whose host bit is 0 keeps its strobe high, so the memory keeps that byte.
- R5: A read holds chip and output enable low with write enable high for RD_WAIT cycles. The bus is sampled at the last of those edges, and read-valid is high for exactly one cycle, starting RD_WAIT edges after acceptance.
- R6: In returned read data, a byte whose lane was not enabled reads as 0x00, whatever the bus carries on that lane.
- R7: The data drivers are never on while output enable is low. After a read, ready stays low for TURN further cycles with all strobes high.
- R8: A request is accepted only on an edge where valid and ready are both high, and ready is low from the next cycle until the access completes.
- R9: Write-done is a one-cycle pulse that goes high WR_PULSE+2 edges after the request is accepted. Ready is high in that same cycle.
- R10: A request with both host enable bits 0 still completes with its normal pulse and timing. The memory is left unchanged, and a read of that kind returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| req_be | input | DATA_W/8 | Byte-lane enables, active high, bit 0 = bits 7:0 |
| rsp_rvalid | output | 1 | One-cycle read completion |
| rsp_rdata | output | DATA_W | Read data, disabled lanes zero |
| rsp_wdone | output | 1 | One-cycle write completion |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_bl_n | output | DATA_W/8 | Byte-lane strobes, active low |
| mem_addr | output | ADDR_W | Memory address |
| mem_dq_out | output | DATA_W | Data driven toward the memory |
| mem_dq_oe | output | 1 | Enables the controller's data drivers |
| mem_dq_in | input | DATA_W | Data returned from the memory |

## Verification
The bench attaches a cycle-level memory model. On every rising edge of write enable, the model checks how long the pulse lasted and how long the data had been stable. A controller that shortened the pulse, changed data inside it or dropped chip enable early would fail those checks. Each of the four lane patterns is written to its own address and then read back whole, so a design that swapped the lanes or wrote a lane whose strobe should be high would leave the wrong bytes behind. Reads with one or neither lane enabled expose unmasked junk, because the model drives a distinctive junk value on disabled lanes. Strict latency checks on read-valid, write-done and ready catch an off-by-one wait or a missing turnaround cycle.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_WSET  = 3'd1,
        ST_WPUL  = 3'd2,
        ST_WHLD  = 3'd3,
        ST_RWAIT = 3'd4,
        ST_TURN  = 3'd5
    } seq_state_t;

endpackage

// File: rtl/sram_lane_mask.sv
module sram_lane_mask #(
    parameter int LANES = 2
) (
    input  logic [LANES-1:0]   host_be,
    input  logic [LANES-1:0]   act_bl_n,
    input  logic [LANES*8-1:0] raw_rd,
    output logic [LANES-1:0]   host_bl_n,
    output logic [LANES*8-1:0] rd_masked
);

    // One slice per byte lane: host enable to strobe, bus byte to masked byte
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign host_bl_n[i]         = ~host_be[i];
        assign rd_masked[i*8 +: 8]  = act_bl_n[i] ? 8'h00 : raw_rd[i*8 +: 8];
    end

endmodule

// File: rtl/sram_lane_seq.sv
module sram_lane_seq
    import sram_lane_pkg::*;
#(
    parameter int ADDR_W   = 18,
    parameter int DATA_W   = 16,
    parameter int WR_PULSE = 1,
    parameter int RD_WAIT  = 2,
    parameter int TURN     = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [DATA_W-1:0]    req_wdata,
    input  logic [DATA_W/8-1:0]  host_bl_n,
    input  logic [DATA_W-1:0]    rd_masked,
    output logic                 req_ready,
    output logic                 rsp_rvalid,
    output logic [DATA_W-1:0]    rsp_rdata,
    output logic                 rsp_wdone,
    output logic                 mem_ce_n,
    output logic                 mem_oe_n,
    output logic                 mem_we_n,
    output logic [DATA_W/8-1:0]  mem_bl_n,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [DATA_W-1:0]    mem_dq_out,
    output logic                 mem_dq_oe
);

    localparam int LANES = DATA_W / 8;
    localparam int MAXC  = (WR_PULSE > RD_WAIT) ? ((WR_PULSE > TURN) ? WR_PULSE : TURN)
                                                : ((RD_WAIT > TURN) ? RD_WAIT : TURN);
    localparam int CNT_W = $clog2(MAXC + 1);

    typedef struct packed {
        seq_state_t        st;
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [LANES-1:0]  bl_n;
        logic              ce_n;
        logic              oe_n;
        logic              we_n;
        logic              dq_oe;
        logic [DATA_W-1:0] rdata;
        logic              rvalid;
        logic              wdone;
    } seq_t;

    localparam seq_t SEQ_RST = '{
        st: ST_IDLE, cnt: '0, addr: '0, wdata: '0, bl_n: '1,
        ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b0,
        rdata: '0, rvalid: 1'b0, wdone: 1'b0
    };

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d        = seq_q;
        seq_d.rvalid = 1'b0;
        seq_d.wdone  = 1'b0;
        case (seq_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    seq_d.addr  = req_addr;
                    seq_d.wdata = req_wdata;
                    seq_d.bl_n  = host_bl_n;
                    seq_d.ce_n  = 1'b0;
                    if (req_write) begin
                        seq_d.st    = ST_WSET;
                        seq_d.dq_oe = 1'b1;
                    end else begin
                        seq_d.st   = ST_RWAIT;
                        seq_d.oe_n = 1'b0;
                        seq_d.cnt  = CNT_W'(RD_WAIT - 1);
                    end
                end
            end
            ST_WSET: begin
                seq_d.st   = ST_WPUL;
                seq_d.we_n = 1'b0;
                seq_d.cnt  = CNT_W'(WR_PULSE - 1);
            end
            ST_WPUL: begin
                if (seq_q.cnt == '0) begin
                    seq_d.st   = ST_WHLD;
                    seq_d.we_n = 1'b1;
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            ST_WHLD: begin
                seq_d.st    = ST_IDLE;
                seq_d.ce_n  = 1'b1;
                seq_d.dq_oe = 1'b0;
                seq_d.bl_n  = '1;
                seq_d.wdone = 1'b1;
            end
            ST_RWAIT: begin
                if (seq_q.cnt == '0) begin
                    seq_d.rdata  = rd_masked;
                    seq_d.rvalid = 1'b1;
                    seq_d.ce_n   = 1'b1;
                    seq_d.oe_n   = 1'b1;
                    seq_d.bl_n   = '1;
                    if (TURN > 0) begin
                        seq_d.st  = ST_TURN;
                        seq_d.cnt = CNT_W'(TURN - 1);
                    end else begin
                        seq_d.st = ST_IDLE;
                    end
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            ST_TURN: begin
                if (seq_q.cnt == '0) seq_d.st = ST_IDLE;
                else                 seq_d.cnt = seq_q.cnt - 1'b1;
            end
            default: seq_d = SEQ_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= SEQ_RST;
        else        seq_q <= seq_d;
    end

    assign req_ready  = (seq_q.st == ST_IDLE);
    assign rsp_rvalid = seq_q.rvalid;
    assign rsp_rdata  = seq_q.rdata;
    assign rsp_wdone  = seq_q.wdone;
    assign mem_ce_n   = seq_q.ce_n;
    assign mem_oe_n   = seq_q.oe_n;
    assign mem_we_n   = seq_q.we_n;
    assign mem_bl_n   = seq_q.bl_n;
    assign mem_addr   = seq_q.addr;
    assign mem_dq_out = seq_q.wdata;
    assign mem_dq_oe  = seq_q.dq_oe;

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe && (&mem_bl_n)));

    // R2
    wr_data_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (mem_dq_oe && $stable(mem_dq_out) && $stable(mem_addr) && $stable(mem_bl_n)));

    // R3
    we_under_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> !mem_ce_n);

    // R7
    no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> !mem_dq_oe);

    // R5
    rvalid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_rvalid |=> !rsp_rvalid);

    // R9
    wdone_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_wdone |=> !rsp_wdone);

    // R8
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl #(
    parameter int ADDR_W   = 18,
    parameter int DATA_W   = 16,
    parameter int WR_PULSE = 1,
    parameter int RD_WAIT  = 2,
    parameter int TURN     = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic                 req_write,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [DATA_W-1:0]    req_wdata,
    input  logic [DATA_W/8-1:0]  req_be,
    output logic                 rsp_rvalid,
    output logic [DATA_W-1:0]    rsp_rdata,
    output logic                 rsp_wdone,
    output logic                 mem_ce_n,
    output logic                 mem_oe_n,
    output logic                 mem_we_n,
    output logic [DATA_W/8-1:0]  mem_bl_n,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [DATA_W-1:0]    mem_dq_out,
    output logic                 mem_dq_oe,
    input  logic [DATA_W-1:0]    mem_dq_in
);

    localparam int LANES = DATA_W / 8;

    logic [LANES-1:0]  host_bl_n;
    logic [DATA_W-1:0] rd_masked;
    logic [LANES-1:0]  act_bl_n;

    assign mem_bl_n = act_bl_n;

    sram_lane_mask #(.LANES(LANES)) u_mask (
        .host_be   (req_be),
        .act_bl_n  (act_bl_n),
        .raw_rd    (mem_dq_in),
        .host_bl_n (host_bl_n),
        .rd_masked (rd_masked)
    );

    sram_lane_seq #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .WR_PULSE (WR_PULSE),
        .RD_WAIT  (RD_WAIT),
        .TURN     (TURN)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .host_bl_n  (host_bl_n),
        .rd_masked  (rd_masked),
        .req_ready  (req_ready),
        .rsp_rvalid (rsp_rvalid),
        .rsp_rdata  (rsp_rdata),
        .rsp_wdone  (rsp_wdone),
        .mem_ce_n   (mem_ce_n),
        .mem_oe_n   (mem_oe_n),
        .mem_we_n   (mem_we_n),
        .mem_bl_n   (act_bl_n),
        .mem_addr   (mem_addr),
        .mem_dq_out (mem_dq_out),
        .mem_dq_oe  (mem_dq_oe)
    );

endmodule

// File: tb/sram_lane_ctrl_test.sv
module sram_lane_ctrl_test;

    localparam int AW    = 6;
    localparam int DW    = 16;
    localparam int WRP   = 2;
    localparam int RDW   = 2;
    localparam int TRN   = 1;
    localparam int WORDS = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [1:0]    req_be = '0;
    logic          rsp_rvalid;
    logic [DW-1:0] rsp_rdata;
    logic          rsp_wdone;
    logic          mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [1:0]    mem_bl_n;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_dq_out;
    logic [DW-1:0] mem_dq_in;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    sram_lane_ctrl #(
        .ADDR_W(AW), .DATA_W(DW), .WR_PULSE(WRP), .RD_WAIT(RDW), .TURN(TRN)
    ) uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .rsp_rvalid(rsp_rvalid), .rsp_rdata(rsp_rdata), .rsp_wdone(rsp_wdone),
        .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_bl_n(mem_bl_n), .mem_addr(mem_addr), .mem_dq_out(mem_dq_out),
        .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Memory model: cycle-level, disabled lanes and deselect return junk
    logic [DW-1:0] sram    [WORDS];
    logic [DW-1:0] exp_mem [WORDS];
    logic          p_we = 1'b1, p_ce = 1'b1, p_oe_drv = 1'b0;
    logic [1:0]    p_bl = 2'b11;
    logic [AW-1:0] p_addr = '0;
    logic [DW-1:0] p_dq = '0;
    int            lowc = 0;
    int            stab = 0;

    assign mem_dq_in = (!mem_ce_n && !mem_oe_n && mem_we_n)
        ? {(mem_bl_n[1] ? 8'hC3 : sram[mem_addr][15:8]),
           (mem_bl_n[0] ? 8'h3C : sram[mem_addr][7:0])}
        : 16'hDEAD;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!mem_oe_n) check("R7 drivers off while output enable low", {31'd0, mem_dq_oe}, 32'd0);
            if (mem_we_n && !p_we) begin
                check("R3 write pulse length", lowc, WRP);
                check("R3 chip enable during pulse", {31'd0, p_ce}, 32'd0);
                check("R2 data stable span before rise", {31'd0, (stab >= WRP + 1)}, 32'd1);
                check("R2 data held after rise", {31'd0, (mem_dq_oe && mem_dq_out == p_dq && mem_addr == p_addr)}, 32'd1);
                if (!p_bl[0]) sram[p_addr][7:0]  = p_dq[7:0];
                if (!p_bl[1]) sram[p_addr][15:8] = p_dq[15:8];
            end
            if (!mem_we_n) lowc++;
            else           lowc = 0;
            if (mem_dq_oe && p_oe_drv && mem_dq_out == p_dq && mem_addr == p_addr) stab++;
            else stab = mem_dq_oe ? 1 : 0;
            p_we = mem_we_n; p_ce = mem_ce_n; p_bl = mem_bl_n;
            p_addr = mem_addr; p_dq = mem_dq_out; p_oe_drv = mem_dq_oe;
        end
    end

    task automatic do_write(input int a, input logic [DW-1:0] d, input logic [1:0] be);
        int lat;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = AW'(a); req_wdata = d; req_be = be;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        check("R8 ready low after accept", {31'd0, req_ready}, 32'd0);
        while (!rsp_wdone && lat < 40) begin @(negedge clk); lat++; end
        check("R9 write done latency", lat, WRP + 3);
        check("R9 ready with done", {31'd0, req_ready}, 32'd1);
        @(negedge clk);
        check("R9 done single cycle", {31'd0, rsp_wdone}, 32'd0);
        if (be[0]) exp_mem[a][7:0]  = d[7:0];
        if (be[1]) exp_mem[a][15:8] = d[15:8];
    endtask

    task automatic do_read(input int a, input logic [1:0] be, output logic [DW-1:0] q);
        int lat;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = AW'(a); req_be = be;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        check("R5 read strobes", {29'd0, mem_ce_n, mem_oe_n, mem_we_n}, 32'd1);
        while (!rsp_rvalid && lat < 40) begin @(negedge clk); lat++; end
        check("R5 read valid latency", lat, RDW + 1);
        check("R7 turnaround ready", {31'd0, req_ready}, (TRN == 0) ? 32'd1 : 32'd0);
        check("R7 strobes high in turnaround", {29'd0, mem_ce_n, mem_oe_n, mem_we_n}, 32'd7);
        q = rsp_rdata;
        @(negedge clk);
        check("R5 valid single cycle", {31'd0, rsp_rvalid}, 32'd0);
    endtask

    function automatic logic [DW-1:0] lane_mask(input logic [1:0] be);
        return {{8{be[1]}}, {8{be[0]}}};
    endfunction

    initial begin
        for (int i = 0; i < WORDS; i++) begin sram[i] = '0; exp_mem[i] = '0; end
    end

    initial begin
        logic [DW-1:0] q;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1 ready after reset", {31'd0, req_ready}, 32'd1);
        check("R1 strobes after reset", {28'd0, mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe}, 32'he);
        check("R1 lane strobes after reset", {30'd0, mem_bl_n}, 32'd3);
        check("R1 no completions", {30'd0, rsp_rvalid, rsp_wdone}, 32'd0);

        // Full-word sweep
        for (int a = 0; a < WORDS; a++)
            do_write(a, DW'((a * 16'h0101) ^ 16'h5A3C), 2'b11);
        for (int a = 0; a < WORDS; a++) begin
            do_read(a, 2'b11, q);
            check("R4 full word readback", {16'd0, q}, {16'd0, exp_mem[a]});
        end

        // Lane-pattern sweep, be = a mod 4 (includes empty enables, R10)
        for (int a = 0; a < WORDS; a++)
            do_write(a, ~DW'(a * 16'h0203), 2'(a % 4));
        for (int a = 0; a < WORDS; a++) begin
            do_read(a, 2'b11, q);
            check("R4 R10 lane merge readback", {16'd0, q}, {16'd0, exp_mem[a]});
        end

        // Partial reads: masked lanes return zero
        for (int a = 0; a < 16; a++) begin
            logic [1:0] be = 2'(a % 4);
            do_read(a, be, q);
            check("R6 R10 masked read", {16'd0, q}, {16'd0, exp_mem[a] & lane_mask(be)});
        end

        // Read immediately followed by write to same address
        do_read(5, 2'b11, q);
        check("R7 read before write", {16'd0, q}, {16'd0, exp_mem[5]});
        do_write(5, 16'hBEEF, 2'b10);
        do_read(5, 2'b11, q);
        check("R4 upper-only write", {16'd0, q}, {16'd0, exp_mem[5]});

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule